// File: doc/BRIEF.md
# Compartment-Tagged Register File

This block is a small general-purpose register file for a processor that runs mutually distrusting programs in isolated compartments. Next to its data value, each register keeps a tag: the number of the compartment whose code produced that value. The running compartment's number arrives on `cur_id`. Every access that would expose a register's plaintext checks the stored tag against `cur_id`. A mismatch raises a one-cycle access fault that names the offending register.

A privileged kernel is not trusted with plaintext. It still has to spill and refill registers on a context switch. A save operation therefore hands the raw value and its tag to an external cipher path, which selects the key from the tag, and no tag check is made. A restore writes a value back under a tag that the restoring code names.

Secure loads and ordinary register writes claim the destination register for the running compartment. Secure stores forward the value and tag to the same external path, but only when the running compartment owns the source register.

Each operation is presented for one clock cycle on `op`. A controller state machine registers its response, so every result appears in the cycle after the operation. The machine has five states:

- `ST_IDLE`: nothing is presented.
- `ST_OPERANDS`: two operands are valid.
- `ST_STORE_OUT`: a store payload is valid.
- `ST_SAVE_OUT`: a save payload is valid.
- `ST_FAULT`: an access fault is signalled.

The next state depends only on the current operation, never on the previous state:

- A use moves to `ST_OPERANDS` when both operand tags match `cur_id`, and to `ST_FAULT` otherwise.
- A store moves to `ST_STORE_OUT` when the source tag matches, and to `ST_FAULT` otherwise.
- A save always moves to `ST_SAVE_OUT`.
- Every write operation, a no-op and the reserved code move to `ST_IDLE`.

Top module: `tagged_regfile`

## Requirements
- R1: After reset (active-low `rst_n`, asynchronous), all 16 registers hold data 0 and tag 0, and none of `exc_valid`, `opnd_valid`, `store_valid` or `save_valid` is high.
- R2: Operation code 2 (define) writes `wr_data` into register `rd` and sets its tag to `cur_id`, without any check.
- R3: Operation code 1 (use) reads registers `rs_a` and `rs_b`. When both tags equal `cur_id`, the next cycle shows `opnd_valid` high with the two values on `opa_data` and `opb_data`.
- R4: When a use finds a tag different from `cur_id`, the next cycle shows `exc_valid` high and no operand valid. `exc_idx` then names `rs_a` if its tag mismatched, and `rs_b` otherwise.
- R5: Operation code 4 (secure load) writes `wr_data` into `rd` and sets its tag to `cur_id`.
- R6: Operation code 3 (secure store) with a source `rs_a` tag equal to `cur_id` gives, in the next cycle, `store_valid` high with the register's value on `xfer_data` and its tag on `xfer_tag`.
- R7: A secure store whose source tag differs from `cur_id` gives `exc_valid` in the next cycle with `exc_idx` equal to `rs_a`, and no store payload.
- R8: Operation code 5 (privileged save) gives, in the next cycle, `save_valid` high with the value and tag of `rs_a` on `xfer_data` and `xfer_tag`, whatever `cur_id` is.
- R9: Operation code 6 (privileged restore) writes `wr_data` into `rd` with tag `restore_tag`, ignoring `cur_id`.
- R10: At most one of the four valid outputs is high in any cycle. A fault lasts exactly one cycle unless the following operation also faults.
- R11: Operation codes 0 (no-op) and 7 (reserved) change no register and give no valid output in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 3 | Operation code for this cycle |
| cur_id | input | 4 | Identifier of the running compartment |
| rs_a | input | 4 | First source register index |
| rs_b | input | 4 | Second source register index |
| rd | input | 4 | Destination register index |
| wr_data | input | 32 | Value to write (define, load, restore) |
| restore_tag | input | 4 | Tag applied by a restore |
| opa_data | output | 32 | First operand value |
| opb_data | output | 32 | Second operand value |
| opnd_valid | output | 1 | Operands valid |
| xfer_data | output | 32 | Value sent to the cipher path |
| xfer_tag | output | 4 | Tag sent with that value |
| store_valid | output | 1 | Store payload valid |
| save_valid | output | 1 | Save payload valid |
| exc_valid | output | 1 | Access fault pulse |
| exc_idx | output | 4 | Register that caused the fault |

## Verification
The bound checker watches the cycle-level response of the controller on every cycle:
- the four valid outputs are mutually exclusive;
- each use or store gives either its payload or a fault one cycle later;
- a save always gives a payload, whatever `cur_id` is;
- writes and no-ops give nothing;
- any reported fault index is one of the source indices of the previous operation.

Several behaviours can only be shown by the bench's scenarios, because they depend on earlier writes:
- whether the tag stored by a define, load or restore is the right one;
- whether a register claimed by one compartment later faults for another;
- the priority of port A in the reported index;
- that a reset clears previously claimed tags.

// File: rtl/tagrf_pkg.sv
package tagrf_pkg;

    typedef enum logic [2:0] {
        OP_NOP     = 3'd0,
        OP_USE     = 3'd1,
        OP_DEFINE  = 3'd2,
        OP_STORE   = 3'd3,
        OP_LOAD    = 3'd4,
        OP_SAVE    = 3'd5,
        OP_RESTORE = 3'd6,
        OP_RSVD    = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_OPERANDS  = 3'd1,
        ST_STORE_OUT = 3'd2,
        ST_SAVE_OUT  = 3'd3,
        ST_FAULT     = 3'd4
    } state_e;

    // Shared tag value of the unprotected compartment
    localparam int unsigned SHARED_ID = 0;

endpackage

// File: rtl/tagrf_storage.sv
module tagrf_storage #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [IDX_W-1:0]  rd_idx_a,
    input  logic [IDX_W-1:0]  rd_idx_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [TAG_W-1:0]  rd_tag_a,
    output logic [DATA_W-1:0] rd_data_b,
    output logic [TAG_W-1:0]  rd_tag_b
);
    import tagrf_pkg::*;

    logic [DATA_W-1:0] val_q [NUM_REGS];
    logic [TAG_W-1:0]  own_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        logic hit;
        assign hit = wr_en && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q[g] <= '0;
                own_q[g] <= TAG_W'(SHARED_ID);
            end else if (hit) begin
                val_q[g] <= wr_data;
                own_q[g] <= wr_tag;
            end
        end
    end

    assign rd_data_a = val_q[rd_idx_a];
    assign rd_tag_a  = own_q[rd_idx_a];
    assign rd_data_b = val_q[rd_idx_b];
    assign rd_tag_b  = own_q[rd_idx_b];

endmodule

// File: rtl/tagrf_tag_cmp.sv
module tagrf_tag_cmp #(
    parameter int unsigned TAG_W  = 4,
    parameter int unsigned NPORTS = 2
) (
    input  logic [TAG_W-1:0]       cur_id,
    input  logic [NPORTS*TAG_W-1:0] port_tags,
    output logic [NPORTS-1:0]      mismatch
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        assign mismatch[p] = (port_tags[p*TAG_W +: TAG_W] != cur_id);
    end
endmodule

// File: rtl/tagrf_ctrl.sv
module tagrf_ctrl #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [TAG_W-1:0]  cur_id,
    input  logic [TAG_W-1:0]  restore_tag,
    input  logic [IDX_W-1:0]  rs_a,
    input  logic [IDX_W-1:0]  rs_b,
    input  logic [1:0]        mismatch,
    input  logic [DATA_W-1:0] src_data_a,
    input  logic [TAG_W-1:0]  src_tag_a,
    input  logic [DATA_W-1:0] src_data_b,
    output logic              wr_en,
    output logic [TAG_W-1:0]  wr_tag,
    output logic [DATA_W-1:0] opa_data,
    output logic [DATA_W-1:0] opb_data,
    output logic              opnd_valid,
    output logic [DATA_W-1:0] xfer_data,
    output logic [TAG_W-1:0]  xfer_tag,
    output logic              store_valid,
    output logic              save_valid,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_idx
);
    import tagrf_pkg::*;

    op_e    op_d;
    state_e state_q, state_d;
    logic   [IDX_W-1:0] fault_idx;

    assign op_d = op_e'(op);

    // Write-side decode: who gets to claim the destination tag
    always_comb begin
        wr_en  = 1'b0;
        wr_tag = cur_id;
        unique case (op_d)
            OP_DEFINE, OP_LOAD: begin
                wr_en  = 1'b1;
                wr_tag = cur_id;
            end
            OP_RESTORE: begin
                wr_en  = 1'b1;
                wr_tag = restore_tag;
            end
            default: ;
        endcase
    end

    // Port A has priority when naming the offending register
    assign fault_idx = mismatch[0] ? rs_a : rs_b;

    // Next-state: depends only on the current operation and the tag checks
    always_comb begin
        state_d = ST_IDLE;
        unique case (op_d)
            OP_USE:     state_d = (|mismatch)  ? ST_FAULT : ST_OPERANDS;
            OP_STORE:   state_d = mismatch[0] ? ST_FAULT : ST_STORE_OUT;
            OP_SAVE:    state_d = ST_SAVE_OUT;
            OP_NOP, OP_DEFINE, OP_LOAD, OP_RESTORE, OP_RSVD:
                        state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Payload registers captured alongside the state
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opa_data  <= '0;
            opb_data  <= '0;
            xfer_data <= '0;
            xfer_tag  <= '0;
            exc_idx   <= '0;
        end else begin
            unique case (state_d)
                ST_OPERANDS: begin
                    opa_data <= src_data_a;
                    opb_data <= src_data_b;
                end
                ST_STORE_OUT, ST_SAVE_OUT: begin
                    xfer_data <= src_data_a;
                    xfer_tag  <= src_tag_a;
                end
                ST_FAULT:  exc_idx <= fault_idx;
                ST_IDLE:   ;
                default:   ;
            endcase
        end
    end

    // Moore valid outputs
    assign opnd_valid  = (state_q == ST_OPERANDS);
    assign store_valid = (state_q == ST_STORE_OUT);
    assign save_valid  = (state_q == ST_SAVE_OUT);
    assign exc_valid   = (state_q == ST_FAULT);

endmodule

// File: rtl/tagged_regfile.sv
module tagged_regfile #(
    parameter int unsigned NUM_REGS = 16,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned TAG_W    = 4,
    localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op,
    input  logic [TAG_W-1:0]  cur_id,
    input  logic [IDX_W-1:0]  rs_a,
    input  logic [IDX_W-1:0]  rs_b,
    input  logic [IDX_W-1:0]  rd,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [TAG_W-1:0]  restore_tag,
    output logic [DATA_W-1:0] opa_data,
    output logic [DATA_W-1:0] opb_data,
    output logic              opnd_valid,
    output logic [DATA_W-1:0] xfer_data,
    output logic [TAG_W-1:0]  xfer_tag,
    output logic              store_valid,
    output logic              save_valid,
    output logic              exc_valid,
    output logic [IDX_W-1:0]  exc_idx
);
    logic              wr_en;
    logic [TAG_W-1:0]  wr_tag;
    logic [DATA_W-1:0] data_a, data_b;
    logic [TAG_W-1:0]  tag_a, tag_b;
    logic [1:0]        mismatch;

    tagrf_storage #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_storage (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (rd),
        .wr_data   (wr_data),
        .wr_tag    (wr_tag),
        .rd_idx_a  (rs_a),
        .rd_idx_b  (rs_b),
        .rd_data_a (data_a),
        .rd_tag_a  (tag_a),
        .rd_data_b (data_b),
        .rd_tag_b  (tag_b)
    );

    tagrf_tag_cmp #(
        .TAG_W  (TAG_W),
        .NPORTS (2)
    ) u_cmp (
        .cur_id    (cur_id),
        .port_tags ({tag_b, tag_a}),
        .mismatch  (mismatch)
    );

    tagrf_ctrl #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .TAG_W    (TAG_W)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .cur_id      (cur_id),
        .restore_tag (restore_tag),
        .rs_a        (rs_a),
        .rs_b        (rs_b),
        .mismatch    (mismatch),
        .src_data_a  (data_a),
        .src_tag_a   (tag_a),
        .src_data_b  (data_b),
        .wr_en       (wr_en),
        .wr_tag      (wr_tag),
        .opa_data    (opa_data),
        .opb_data    (opb_data),
        .opnd_valid  (opnd_valid),
        .xfer_data   (xfer_data),
        .xfer_tag    (xfer_tag),
        .store_valid (store_valid),
        .save_valid  (save_valid),
        .exc_valid   (exc_valid),
        .exc_idx     (exc_idx)
    );

endmodule

// File: rtl/tagged_regfile_chk.sv
module tagged_regfile_chk #(
    parameter int unsigned IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op,
    input logic [IDX_W-1:0] rs_a,
    input logic [IDX_W-1:0] rs_b,
    input logic             opnd_valid,
    input logic             store_valid,
    input logic             save_valid,
    input logic             exc_valid,
    input logic [IDX_W-1:0] exc_idx
);
    import tagrf_pkg::*;

    // R10
    one_response_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({opnd_valid, store_valid, save_valid, exc_valid}));

    // R3
    use_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_USE)) |=> (opnd_valid || exc_valid));

    // R4
    fault_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_USE) || op == 3'(OP_STORE)) |=>
            (!exc_valid || exc_idx == $past(rs_a) || exc_idx == $past(rs_b)));

    // R6
    store_answers_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_STORE)) |=> (store_valid || exc_valid));

    // R7
    store_fault_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_STORE)) |=> (!exc_valid || exc_idx == $past(rs_a)));

    // R8
    save_never_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_SAVE)) |=> save_valid);

    // R11
    quiet_ops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'(OP_NOP) || op == 3'(OP_RSVD) || op == 3'(OP_DEFINE) ||
         op == 3'(OP_LOAD) || op == 3'(OP_RESTORE)) |=>
            !(opnd_valid || store_valid || save_valid || exc_valid));

endmodule

bind tagged_regfile tagged_regfile_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op          (op),
    .rs_a        (rs_a),
    .rs_b        (rs_b),
    .opnd_valid  (opnd_valid),
    .store_valid (store_valid),
    .save_valid  (save_valid),
    .exc_valid   (exc_valid),
    .exc_idx     (exc_idx)
);

// File: tb/tagged_regfile_test.sv
`timescale 1ns/1ps
module tagged_regfile_test;

    // Response kinds: 0 nothing, 1 operands, 2 store, 3 save, 4 fault
    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  op;
        logic [3:0]  cur;
        logic [3:0]  ra;
        logic [3:0]  rb;
        logic [3:0]  rd;
        logic [31:0] wdata;
        logic [3:0]  rtag;
        logic [2:0]  ek;
        logic [31:0] e1;
        logic [31:0] e2;
        logic [3:0]  etag;
        logic [3:0]  eidx;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        // R2: compartment 3 claims r1 and r2
        '{4'd2, 3'd2, 4'd3, 4'd0, 4'd0, 4'd1, 32'h11111111, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        '{4'd2, 3'd2, 4'd3, 4'd0, 4'd0, 4'd2, 32'h22222222, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        // R3: owner reads both
        '{4'd3, 3'd1, 4'd3, 4'd1, 4'd2, 4'd0, 32'h0, 4'd0, 3'd1, 32'h11111111, 32'h22222222, 4'd0, 4'd0},
        // R4: foreign compartment, port A flagged
        '{4'd4, 3'd1, 4'd5, 4'd1, 4'd2, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd1},
        // R4: only port B mismatches (r0 is shared tag 0)
        '{4'd4, 3'd1, 4'd3, 4'd1, 4'd0, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd0},
        // R10: fault does not linger
        '{4'd10, 3'd0, 4'd3, 4'd0, 4'd0, 4'd0, 32'h0, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        // R5: secure load by compartment 5
        '{4'd5, 3'd4, 4'd5, 4'd0, 4'd0, 4'd4, 32'hA5A5A5A5, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        // R6: owner store
        '{4'd6, 3'd3, 4'd5, 4'd4, 4'd0, 4'd0, 32'h0, 4'd0, 3'd2, 32'hA5A5A5A5, 32'h0, 4'd5, 4'd0},
        // R7: foreign store
        '{4'd7, 3'd3, 4'd3, 4'd4, 4'd9, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd4},
        // R8: privileged save from another compartment
        '{4'd8, 3'd5, 4'd7, 4'd4, 4'd0, 4'd0, 32'h0, 4'd0, 3'd3, 32'hA5A5A5A5, 32'h0, 4'd5, 4'd0},
        // R9: restore into r6 under tag 3 while 7 runs
        '{4'd9, 3'd6, 4'd7, 4'd0, 4'd0, 4'd6, 32'hDEADBEEF, 4'd3, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        '{4'd9, 3'd1, 4'd3, 4'd6, 4'd1, 4'd0, 32'h0, 4'd0, 3'd1, 32'hDEADBEEF, 32'h11111111, 4'd0, 4'd0},
        '{4'd9, 3'd1, 4'd7, 4'd6, 4'd6, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd6},
        // R10: back-to-back faults stay high
        '{4'd10, 3'd3, 4'd7, 4'd2, 4'd0, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd2},
        // R2: redefining r1 moves ownership to 9
        '{4'd2, 3'd2, 4'd9, 4'd0, 4'd0, 4'd1, 32'h12345678, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        '{4'd2, 3'd1, 4'd3, 4'd2, 4'd1, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd1},
        '{4'd8, 3'd5, 4'd0, 4'd1, 4'd0, 4'd0, 32'h0, 4'd0, 3'd3, 32'h12345678, 32'h0, 4'd9, 4'd0},
        // R4: both ports mismatch, A wins
        '{4'd4, 3'd1, 4'd0, 4'd2, 4'd1, 4'd0, 32'h0, 4'd0, 3'd4, 32'h0, 32'h0, 4'd0, 4'd2},
        // R11: reserved code writes nothing (r2 stays)
        '{4'd11, 3'd7, 4'd3, 4'd0, 4'd0, 4'd2, 32'hFFFFFFFF, 4'd0, 3'd0, 32'h0, 32'h0, 4'd0, 4'd0},
        '{4'd11, 3'd5, 4'd3, 4'd2, 4'd0, 4'd0, 32'h0, 4'd0, 3'd3, 32'h22222222, 32'h0, 4'd3, 4'd0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [3:0]  cur_id = '0, rs_a = '0, rs_b = '0, rd = '0, restore_tag = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] opa_data, opb_data, xfer_data;
    logic [3:0]  xfer_tag, exc_idx;
    logic        opnd_valid, store_valid, save_valid, exc_valid;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    tagged_regfile uut (
        .clk(clk), .rst_n(rst_n), .op(op), .cur_id(cur_id),
        .rs_a(rs_a), .rs_b(rs_b), .rd(rd), .wr_data(wr_data),
        .restore_tag(restore_tag),
        .opa_data(opa_data), .opb_data(opb_data), .opnd_valid(opnd_valid),
        .xfer_data(xfer_data), .xfer_tag(xfer_tag),
        .store_valid(store_valid), .save_valid(save_valid),
        .exc_valid(exc_valid), .exc_idx(exc_idx)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one operation at a falling edge, return at the next falling edge
    task automatic apply(input logic [2:0] o, input logic [3:0] c, input logic [3:0] a,
                         input logic [3:0] b, input logic [3:0] d,
                         input logic [31:0] w, input logic [3:0] t);
        op = o; cur_id = c; rs_a = a; rs_b = b; rd = d; wr_data = w; restore_tag = t;
        @(negedge clk);
        op = 3'd0;
    endtask

    task automatic expect_resp(input string req, input logic [2:0] ek,
                               input logic [31:0] e1, input logic [31:0] e2,
                               input logic [3:0] etag, input logic [3:0] eidx);
        logic [3:0] fl_exp, fl_act;
        fl_exp = {ek == 3'd4, ek == 3'd1, ek == 3'd2, ek == 3'd3};
        fl_act = {exc_valid, opnd_valid, store_valid, save_valid};
        check(fl_act == fl_exp, req, 64'(fl_act), 64'(fl_exp));
        case (ek)
            3'd1: check(opa_data == e1 && opb_data == e2, req,
                        {opa_data, opb_data}, {e1, e2});
            3'd2, 3'd3: check(xfer_data == e1 && xfer_tag == etag, req,
                              {28'd0, xfer_tag, xfer_data}, {28'd0, etag, e1});
            3'd4: check(exc_idx == eidx, req, 64'(exc_idx), 64'(eidx));
            default: ;
        endcase
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        op = 3'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        do_reset();
        // R1: nothing valid after reset
        expect_resp("R1 idle after reset", 3'd0, 32'h0, 32'h0, 4'd0, 4'd0);
        // R1: shared compartment reads reset registers as zero
        apply(3'd1, 4'd0, 4'd0, 4'd15, 4'd0, 32'h0, 4'd0);
        expect_resp("R1 reset values", 3'd1, 32'h0, 32'h0, 4'd0, 4'd0);
        // R1: reset tag is 0, seen through a save of r15
        apply(3'd5, 4'd6, 4'd15, 4'd0, 4'd0, 32'h0, 4'd0);
        expect_resp("R1 reset tag", 3'd3, 32'h0, 32'h0, 4'd0, 4'd0);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].cur, VECS[i].ra, VECS[i].rb, VECS[i].rd,
                  VECS[i].wdata, VECS[i].rtag);
            expect_resp($sformatf("R%0d vector %0d", VECS[i].req, i), VECS[i].ek,
                        VECS[i].e1, VECS[i].e2, VECS[i].etag, VECS[i].eidx);
        end

        // R9: restore may hand ownership to the shared compartment
        apply(3'd6, 4'd7, 4'd0, 4'd0, 4'd15, 32'h0BADF00D, 4'd0);
        apply(3'd1, 4'd0, 4'd15, 4'd0, 4'd0, 32'h0, 4'd0);
        expect_resp("R9 restore to shared tag", 3'd1, 32'h0BADF00D, 32'h0, 4'd0, 4'd0);

        // R1: a mid-run reset clears claimed registers (r6 held tag 3)
        do_reset();
        apply(3'd1, 4'd0, 4'd6, 4'd4, 4'd0, 32'h0, 4'd0);
        expect_resp("R1 reset clears tags", 3'd1, 32'h0, 32'h0, 4'd0, 4'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule